// File: doc/BRIEF.md
# Sideband Tracker for a Variable-Latency Compute Unit

This block wraps a compute unit whose latency is not fixed. Each request carries an operand and a sideband word. The operand goes to the unit. The sideband word waits in a small FIFO inside the block. The unit returns results in the order it received requests. When the next result reaches the output, the oldest waiting sideband word leaves with it, so every result carries the sideband of the request that produced it. A fixed-length delay line cannot give this pairing, because the number of cycles between request and result changes from one request to the next.

The block has three interfaces: an upstream valid/ready request port, a request/response port to the unit, and a downstream valid/ready result port. A request is taken only when the unit can accept it and the FIFO still has a free entry. By default the FIFO depth equals the greatest number of operations the unit can hold in flight. Results wait in a single output register. While that register is full and the consumer stalls, the unit's response port is held back.

Top module: `sideband_tracker`

## Requirements
- R1: `in_ready` is high only while `cu_req_ready` is high; while the unit is not ready, no request is accepted.
- R2: When `cu_req_valid` is high, `cu_req_operand` equals `in_operand` in the same cycle.
- R3: Each result leaves with the sideband word of the request that produced it, in request order. No output is produced without an earlier accepted request, and a unit response that arrives while no sideband word is waiting is a protocol violation.
- R4: `out_result` equals the `cu_rsp_result` value captured for that result, unchanged.
- R5: While `out_valid` is high and `out_ready` is low, `out_result` and `out_sideband` hold steady, `out_valid` stays high, and `cu_rsp_ready` is low.
- R6: A cycle in which a request is accepted and a result leaves leaves the FIFO occupancy unchanged.
- R7: With FIFO_DEPTH sideband words waiting, `in_ready` and `cu_req_valid` are low even when `cu_req_ready` is high.
- R8: After reset the FIFO is empty: `out_valid` is 0, `cu_rsp_ready` is 1, and `in_ready` follows `cu_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream request valid |
| in_ready | output | 1 | Upstream request accepted when high with valid |
| in_operand | input | OP_W | Operand for the unit |
| in_sideband | input | SB_W | Sideband word paired with the request |
| cu_req_valid | output | 1 | Request valid toward the unit |
| cu_req_ready | input | 1 | Unit can take a request |
| cu_req_operand | output | OP_W | Operand sent to the unit |
| cu_rsp_valid | input | 1 | Unit has a result |
| cu_rsp_ready | output | 1 | Block takes the unit's result |
| cu_rsp_result | input | RES_W | Result from the unit |
| out_valid | output | 1 | Downstream result valid |
| out_ready | input | 1 | Downstream consumer ready |
| out_result | output | RES_W | Result presented downstream |
| out_sideband | output | SB_W | Sideband word paired with the result |

## Verification
The bench builds the block with MAX_INFLIGHT = 3, which gives a three-entry FIFO whose pointers wrap at a depth that is not a power of two. The unit model in the bench can hold four operations. That makes the FIFO-full condition, not the unit, the limit on acceptance, so the full gate can be reached and observed. The model gives each request its own latency, and the downstream ready follows a stall pattern. Together these bring sideband words stacking up, stalls at the output while the unit still has results, and cycles where a push and a pop happen together.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  // number of bits needed to hold a value from 0 to n inclusive
  function automatic int unsigned occ_bits(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // number of bits needed to index n entries
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sbt_fifo.sv
module sbt_fifo
  import sbt_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = idx_bits(DEPTH),
  localparam int unsigned CW   = occ_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);

  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  slot_q [DEPTH];
  logic [DEPTH-1:0] slot_we;
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // per-slot write enable and storage
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_we[g] = push && (wr_q == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_we[g]) begin
        slot_q[g] <= din;
      end
    end
  end

  // pointer and occupancy next state
  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) begin
      wr_d = (wr_q == LAST_IDX) ? '0 : wr_q + PW'(1);
    end
    if (pop) begin
      rd_d = (rd_q == LAST_IDX) ? '0 : rd_q + PW'(1);
    end
    unique case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign head  = slot_q[rd_q];
  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);
  assign count = cnt_q;

endmodule

// File: rtl/sbt_admit.sv
module sbt_admit (
  input  logic in_valid,
  input  logic cu_req_ready,
  input  logic fifo_full,
  output logic in_ready,
  output logic cu_req_valid,
  output logic push
);

  logic room;

  // a request needs both a unit slot and a sideband slot
  always_comb begin
    room         = !fifo_full;
    in_ready     = cu_req_ready && room;
    cu_req_valid = in_valid && room;
    push         = in_valid && in_ready;
  end

endmodule

// File: rtl/sbt_out_stage.sv
module sbt_out_stage #(
  parameter int unsigned RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsp_valid,
  input  logic [RES_W-1:0] rsp_result,
  output logic             rsp_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0] out_result,
  output logic             retire
);

  logic             vld_q, vld_d;
  logic             load;
  logic [RES_W-1:0] res_q;

  always_comb begin
    retire    = vld_q && out_ready;
    rsp_ready = !vld_q || out_ready;
    load      = rsp_valid && rsp_ready;
    vld_d     = vld_q;
    if (load) begin
      vld_d = 1'b1;
    end else if (retire) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // data register, clock-enabled by load, no reset needed
  always_ff @(posedge clk) begin
    if (load) begin
      res_q <= rsp_result;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;

endmodule

// File: rtl/sideband_tracker.sv
module sideband_tracker
  import sbt_pkg::*;
#(
  parameter int unsigned OP_W         = 16,
  parameter int unsigned RES_W        = 16,
  parameter int unsigned SB_W         = 8,
  parameter int unsigned MAX_INFLIGHT = 4,
  parameter int unsigned FIFO_DEPTH   = MAX_INFLIGHT,
  localparam int unsigned CNT_W       = occ_bits(FIFO_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_operand,
  input  logic [SB_W-1:0]  in_sideband,
  output logic             cu_req_valid,
  input  logic             cu_req_ready,
  output logic [OP_W-1:0]  cu_req_operand,
  input  logic             cu_rsp_valid,
  output logic             cu_rsp_ready,
  input  logic [RES_W-1:0] cu_rsp_result,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0] out_result,
  output logic [SB_W-1:0]  out_sideband
);

  logic             fifo_full;
  logic             fifo_empty;
  logic [CNT_W-1:0] fifo_count;
  logic             push;
  logic             pop;

  sbt_admit u_admit (
    .in_valid     (in_valid),
    .cu_req_ready (cu_req_ready),
    .fifo_full    (fifo_full),
    .in_ready     (in_ready),
    .cu_req_valid (cu_req_valid),
    .push         (push)
  );

  assign cu_req_operand = in_operand;

  sbt_fifo #(
    .W     (SB_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .din   (in_sideband),
    .head  (out_sideband),
    .full  (fifo_full),
    .empty (fifo_empty),
    .count (fifo_count)
  );

  sbt_out_stage #(
    .RES_W (RES_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_valid  (cu_rsp_valid),
    .rsp_result (cu_rsp_result),
    .rsp_ready  (cu_rsp_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .retire     (pop)
  );

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
  parameter int unsigned RES_W = 16,
  parameter int unsigned SB_W  = 8,
  parameter int unsigned CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             cu_req_ready,
  input logic             cu_req_valid,
  input logic             cu_rsp_valid,
  input logic             cu_rsp_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RES_W-1:0] out_result,
  input logic [SB_W-1:0]  out_sideband,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic             push,
  input logic             pop,
  input logic [CW-1:0]    count
);

  a_r1_unit_gate: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> cu_req_ready);

  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> (!in_ready && !cu_req_valid));

  a_r3_no_orphan_result: assert property (@(posedge clk) disable iff (!rst_n)
    cu_rsp_valid |-> !fifo_empty);

  a_r3_pop_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);

  a_r5_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_sideband)));

  a_r5_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !cu_rsp_ready);

  a_r6_count_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (count == $past(count)));

endmodule

bind sideband_tracker sbt_checker #(
  .RES_W (RES_W),
  .SB_W  (SB_W),
  .CW    (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .cu_req_ready (cu_req_ready),
  .cu_req_valid (cu_req_valid),
  .cu_rsp_valid (cu_rsp_valid),
  .cu_rsp_ready (cu_rsp_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_result   (out_result),
  .out_sideband (out_sideband),
  .fifo_full    (fifo_full),
  .fifo_empty   (fifo_empty),
  .push         (push),
  .pop          (pop),
  .count        (fifo_count)
);

// File: tb/sideband_tracker_test.sv
`timescale 1ns/1ps
module sideband_tracker_test;

  localparam int OPW = 16;
  localparam int RW  = 16;
  localparam int SBW = 8;
  localparam int UNIT_CAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [OPW-1:0] in_operand = '0;
  logic [SBW-1:0] in_sideband = '0;
  logic cu_req_valid, cu_req_ready;
  logic [OPW-1:0] cu_req_operand;
  logic cu_rsp_valid, cu_rsp_ready;
  logic [RW-1:0] cu_rsp_result;
  logic out_valid, out_ready;
  logic [RW-1:0] out_result;
  logic [SBW-1:0] out_sideband;

  logic cu_stall = 1'b0;
  logic [3:0] lat_cur = 4'd1;
  logic or_auto = 1'b0;
  logic or_force = 1'b0;
  int tcyc = 0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sideband_tracker #(
    .OP_W(OPW), .RES_W(RW), .SB_W(SBW), .MAX_INFLIGHT(3)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_sideband(in_sideband),
    .cu_req_valid(cu_req_valid), .cu_req_ready(cu_req_ready),
    .cu_req_operand(cu_req_operand),
    .cu_rsp_valid(cu_rsp_valid), .cu_rsp_ready(cu_rsp_ready),
    .cu_rsp_result(cu_rsp_result),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_sideband(out_sideband)
  );

  function automatic logic [RW-1:0] unit_fn(input logic [OPW-1:0] op);
    return RW'(op * 3 + 16'h0101);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---- in-order unit model with per-request latency ----
  logic [OPW-1:0] m_op  [64];
  logic [3:0]     m_lat [64];
  int             m_t   [64];
  logic [5:0]     m_hd, m_tl, m_cnt;

  assign m_cnt         = m_tl - m_hd;
  assign cu_req_ready  = (m_cnt < 6'(UNIT_CAP)) && !cu_stall;
  assign cu_rsp_valid  = (m_cnt != 0) && ((tcyc - m_t[m_hd]) >= int'(m_lat[m_hd]));
  assign cu_rsp_result = unit_fn(m_op[m_hd]);
  assign out_ready     = or_auto ? ((tcyc % 5) > 1) : or_force;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hd <= '0;
      m_tl <= '0;
      tcyc <= 0;
    end else begin
      tcyc <= tcyc + 1;
      if (cu_req_valid && cu_req_ready) begin
        m_op[m_tl]  <= cu_req_operand;
        m_lat[m_tl] <= lat_cur;
        m_t[m_tl]   <= tcyc;
        m_tl        <= m_tl + 6'd1;
      end
      if (cu_rsp_valid && cu_rsp_ready) m_hd <= m_hd + 6'd1;
    end
  end

  // ---- scoreboard ----
  logic [OPW-1:0] e_op [64];
  logic [SBW-1:0] e_sb [64];
  int e_wr = 0;
  int e_rd = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cu_req_valid)
        chk(cu_req_operand == in_operand, "R2 operand forward", 32'(cu_req_operand), 32'(in_operand));
      if (in_valid && in_ready) begin
        e_op[e_wr % 64] = in_operand;
        e_sb[e_wr % 64] = in_sideband;
        e_wr++;
      end
      if (out_valid && out_ready) begin
        if (e_rd == e_wr) begin
          chk(1'b0, "R3 output without request", 32'(out_sideband), 32'hFFFF_FFFF);
        end else begin
          chk(out_sideband == e_sb[e_rd % 64], "R3 sideband pairing", 32'(out_sideband), 32'(e_sb[e_rd % 64]));
          chk(out_result == unit_fn(e_op[e_rd % 64]), "R4 result value", 32'(out_result), 32'(unit_fn(e_op[e_rd % 64])));
          e_rd++;
        end
      end
    end
  end

  task automatic send(input logic [OPW-1:0] op, input logic [SBW-1:0] sb, input logic [3:0] lat);
    @(posedge clk); #1;
    in_valid = 1'b1; in_operand = op; in_sideband = sb; lat_cur = lat;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    or_auto = 1'b0; or_force = 1'b1;
    while (e_rd != e_wr || m_cnt != 0 || out_valid) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // {operand, sideband, latency}
  localparam logic [31:0] VEC [12] = '{
    32'h1234_A1_03, 32'h0001_B2_01, 32'hFFFF_C3_07, 32'h8000_D4_02,
    32'h00FF_E5_09, 32'h7A7A_F6_01, 32'h0F0F_07_05, 32'hBEEF_18_01,
    32'hCAFE_29_04, 32'h5555_3A_08, 32'hAAAA_4B_01, 32'h0000_5C_02
  };

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'(tcyc), 32'd0);
    summary();
  end

  initial begin
    logic [RW-1:0] held_res;
    logic [SBW-1:0] held_sb;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid in reset", 32'(out_valid), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid after reset", 32'(out_valid), 32'd0);
    chk(cu_rsp_ready == 1'b1, "R8 cu_rsp_ready after reset", 32'(cu_rsp_ready), 32'd1);
    chk(in_ready == 1'b1, "R8 in_ready after reset", 32'(in_ready), 32'd1);

    // table walk with a stalling consumer
    or_auto = 1'b1;
    for (int i = 0; i < 12; i++) begin
      send(VEC[i][31:16], VEC[i][15:8], VEC[i][3:0]);
    end
    drain();
    chk(e_rd == e_wr, "R3 every request answered", 32'(e_rd), 32'(e_wr));

    // R1: unit not ready blocks acceptance
    @(posedge clk); #1;
    cu_stall = 1'b1; in_valid = 1'b1; in_operand = 16'h3333; in_sideband = 8'h77;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R1 unit stall", 32'(in_ready), 32'd0);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; cu_stall = 1'b0;

    // R7: fill the FIFO with consumer stalled
    or_force = 1'b0;
    send(16'h0101, 8'hA0, 4'd1);
    send(16'h0202, 8'hA1, 4'd1);
    send(16'h0303, 8'hA2, 4'd1);
    in_valid = 1'b1; in_operand = 16'h0404; in_sideband = 8'hA3; lat_cur = 4'd1;
    @(negedge clk);
    chk(cu_req_ready == 1'b1, "R7 precondition unit ready", 32'(cu_req_ready), 32'd1);
    chk(in_ready == 1'b0, "R7 full blocks in_ready", 32'(in_ready), 32'd0);
    chk(cu_req_valid == 1'b0, "R7 full blocks cu_req_valid", 32'(cu_req_valid), 32'd0);

    // R5: output held, unit backpressured
    held_res = out_result; held_sb = out_sideband;
    chk(out_valid == 1'b1, "R5 result waiting", 32'(out_valid), 32'd1);
    chk(held_sb == 8'hA0, "R5 oldest sideband shown", 32'(held_sb), 32'hA0);
    chk(cu_rsp_valid && !cu_rsp_ready, "R5 response backpressured", {30'd0, cu_rsp_valid, cu_rsp_ready}, 32'd2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_result == held_res && out_sideband == held_sb && out_valid,
          "R5 held output stable", {out_result, out_sideband, 7'd0, out_valid}, {held_res, held_sb, 8'd1});
    end

    // R6: pop, then simultaneous push and pop, then one push refills
    @(posedge clk); #1;
    or_force = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R6 still full before pop", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk(in_ready && out_valid && out_ready, "R6 push and pop same cycle",
        {29'd0, in_ready, out_valid, out_ready}, 32'd7);
    @(posedge clk); #1;
    or_force = 1'b0; in_operand = 16'h0505; in_sideband = 8'hA4;
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 occupancy unchanged after push+pop", 32'(in_ready), 32'd1);
    @(posedge clk); #1;
    in_operand = 16'h0606; in_sideband = 8'hA5;
    @(negedge clk);
    chk(in_ready == 1'b0, "R6 one push refills to full", 32'(in_ready), 32'd0);
    @(posedge clk); #1;
    in_valid = 1'b0;

    drain();
    chk(e_rd == e_wr, "R3 directed requests answered", 32'(e_rd), 32'(e_wr));
    summary();
  end

endmodule